// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block collects interrupt events for a multi-link cell transport device. Each link has a status register of event bits. A one-cycle event pulse sets a status bit, and the bit stays set until software writes a zero to it. Each link also has an enable register with one bit per source. A single registered, active-high interrupt line asserts while any enabled status bit is set on any link. Software can mask a source while it services that source, and the latched status survives the mask.

Link 0 has two status positions that are live summaries and are not latched.

- **Bit 8** is the OR of a second-level overflow register, gated by that register's own enables. The overflow register has 13 latched sources, cleared by writing zero.
- **Bit 7** combines two events per group: control-cell transfer done and frame end on the reference link. Both events are latched in a companion control/status register. A group contributes to bit 7 only while both its frame enable and its cell enable are set.

Software reaches every register through a simple port: a write strobe, an address and 16-bit data. Reads return data one cycle after the address is presented.

Top module: `irq_link_aggregator`

## Requirements
- R1: After reset, every status, enable and companion register reads 0 and `irq_o` is 0.
- R2: An event pulse sets its link status bit (link l, source s at bit s of address l). Writing 1 to a latched bit leaves it unchanged. Writing 0 clears it.
- R3: When an event pulse and a write of 0 reach the same status bit in the same cycle, the bit stays set.
- R4: `irq_o` is registered. One cycle after the state changes, it equals the OR over all links of (status AND enable). Each link's enable register is at address 0x10+l.
- R5: Clearing an enable bit drops `irq_o` but keeps the status bit set. Setting the enable bit again raises `irq_o` again.
- R6: Link 0 bit 8 reads as the OR of (overflow status AND overflow enable). It falls as soon as the matching overflow enable is cleared. Writes to link 0 bits 7 and 8 have no effect.
- R7: The overflow status register at address 0x20 latches 13 sources and clears by writing 0. Its enable register is at address 0x21. Bit positions are: bit 12 receive FIFO overflow in single-link mode, bits 11:8 input counters, bits 7:4 transmit link counters, bits 3:0 receive link counters.
- R8: Link 0 bit 7 is set when some group g has (ready[g] OR frame[g]) AND frame-enable[g] AND cell-enable[g]. The frame enables are at address 0x23 and the cell enables at address 0x24, bit g for group g. With only one of the two enables set, bit 7 stays 0.
- R9: The companion register at address 0x22 holds cell-transfer-ready bits at 7:0 and frame-end bits at 15:8, bit g / 8+g for group g. Both kinds latch on their event and clear by writing 0.
- R10: Read data for an address appears on `rd_data_o` one cycle after the address is presented. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_LINKS*SRC_W | Event pulses, link l source s at bit l*SRC_W+s |
| ovf_evt_i | input | 13 | Overflow event pulses for the second-level register |
| cell_done_i | input | NUM_GROUPS | Control-cell transfer-complete pulses per group |
| frame_end_i | input | NUM_GROUPS | Reference-link frame-end pulses per group |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register address for read and write |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data, one cycle after address |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest situation to reach is the link 0 bit 7 summary. It needs a latched group event plus two separately written enable registers, and each enable alone must leave the bit low. The bench sweeps every group through cell-done and frame-end pulses. It adds the two enables one at a time and reads link 0 after each step. The same-cycle event and clear race is reached by raising an event pulse in the very cycle of a zero write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int DATA_W = 16;
   localparam int OVF_W  = 13;
   typedef logic [DATA_W-1:0] word_t;
   // register map (6-bit space)
   localparam logic [5:0] LINK_EN_BASE = 6'h10;
   localparam logic [5:0] OVF_STAT_A   = 6'h20;
   localparam logic [5:0] OVF_EN_A     = 6'h21;
   localparam logic [5:0] CELL_CS_A    = 6'h22;
   localparam logic [5:0] FRM_EN_A     = 6'h23;
   localparam logic [5:0] CELL_EN_A    = 6'h24;
   // special link-0 positions
   localparam int SEC_BIT = 7;
   localparam int OVF_BIT = 8;
endpackage

// File: rtl/irq_latch_reg.sv
module irq_latch_reg #(
   parameter int W = 8,
   parameter logic [W-1:0] LATCH_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         wr_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] q_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (LATCH_MASK[i]) begin : g_latch
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             q <= 1'b0;
            else if (set_i[i])      q <= 1'b1;
            else if (wr_i && !wr_data_i[i]) q <= 1'b0;
         end
         assign q_o[i] = q;

         // R2
         set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
         // R2
         write_one_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && wr_data_i[i] && q_o[i]) |=> q_o[i]);
         // R3
         event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && !wr_data_i[i] && set_i[i]) |=> q_o[i]);
      end else begin : g_none
         assign q_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_link_aggregator.sv
module irq_link_aggregator
   import irq_agg_pkg::*;
#(
   parameter int NUM_LINKS  = 4,
   parameter int SRC_W      = 10,
   parameter int NUM_GROUPS = 8,
   parameter int ADDR_W     = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_LINKS*SRC_W-1:0] evt_i,
   input  logic [12:0]                ovf_evt_i,
   input  logic [NUM_GROUPS-1:0]      cell_done_i,
   input  logic [NUM_GROUPS-1:0]      frame_end_i,
   input  logic                       wr_en_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [15:0]                wr_data_i,
   output logic [15:0]                rd_data_o,
   output logic                       irq_o
);
   localparam int CS_W = 2 * NUM_GROUPS;
   localparam logic [SRC_W-1:0] L0_MASK =
      ~((SRC_W'(1) << SEC_BIT) | (SRC_W'(1) << OVF_BIT));

   initial begin
      assert (NUM_LINKS >= 1 && NUM_LINKS <= 16) else $error("NUM_LINKS out of range");
      assert (SRC_W > OVF_BIT && SRC_W <= DATA_W) else $error("SRC_W out of range");
      assert (NUM_GROUPS >= 1 && NUM_GROUPS <= 8) else $error("NUM_GROUPS out of range");
      assert (ADDR_W == 6) else $error("ADDR_W must be 6");
   end

   logic [SRC_W-1:0] stat_q [NUM_LINKS];
   logic [SRC_W-1:0] en_q   [NUM_LINKS];
   logic [SRC_W-1:0] eff    [NUM_LINKS];
   logic [NUM_LINKS-1:0] link_pend;
   logic [NUM_LINKS-1:0] link_en_any;

   // second-level overflow register
   logic [OVF_W-1:0] ovf_q, ovf_en_q;
   logic ovf_sum;
   irq_latch_reg #(.W(OVF_W)) u_ovf (
      .clk(clk), .rst_n(rst_n), .set_i(ovf_evt_i),
      .wr_i(wr_en_i && addr_i == OVF_STAT_A),
      .wr_data_i(wr_data_i[OVF_W-1:0]), .q_o(ovf_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_en_q <= '0;
      else if (wr_en_i && addr_i == OVF_EN_A) ovf_en_q <= wr_data_i[OVF_W-1:0];
   end
   assign ovf_sum = |(ovf_q & ovf_en_q);

   // companion control/status: ready at low half, frame at high half
   logic [CS_W-1:0] cs_q, cs_wd;
   logic [NUM_GROUPS-1:0] rdy_q, frm_q, frm_en_q, cell_en_q;
   logic sec_sum;
   assign cs_wd = {wr_data_i[8 +: NUM_GROUPS], wr_data_i[0 +: NUM_GROUPS]};
   irq_latch_reg #(.W(CS_W)) u_cs (
      .clk(clk), .rst_n(rst_n), .set_i({frame_end_i, cell_done_i}),
      .wr_i(wr_en_i && addr_i == CELL_CS_A),
      .wr_data_i(cs_wd), .q_o(cs_q));
   assign rdy_q = cs_q[NUM_GROUPS-1:0];
   assign frm_q = cs_q[CS_W-1:NUM_GROUPS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_en_q  <= '0;
         cell_en_q <= '0;
      end else if (wr_en_i) begin
         if (addr_i == FRM_EN_A)  frm_en_q  <= wr_data_i[NUM_GROUPS-1:0];
         if (addr_i == CELL_EN_A) cell_en_q <= wr_data_i[NUM_GROUPS-1:0];
      end
   end
   assign sec_sum = |((rdy_q | frm_q) & frm_en_q & cell_en_q);

   // per-link status and enables
   for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
      localparam logic [SRC_W-1:0] MASK = (l == 0) ? L0_MASK : '1;
      irq_latch_reg #(.W(SRC_W), .LATCH_MASK(MASK)) u_stat (
         .clk(clk), .rst_n(rst_n), .set_i(evt_i[l*SRC_W +: SRC_W]),
         .wr_i(wr_en_i && addr_i == ADDR_W'(l)),
         .wr_data_i(wr_data_i[SRC_W-1:0]), .q_o(stat_q[l]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q[l] <= '0;
         else if (wr_en_i && addr_i == LINK_EN_BASE + ADDR_W'(l))
            en_q[l] <= wr_data_i[SRC_W-1:0];
      end

      if (l == 0) begin : g_l0
         always_comb begin
            eff[l] = stat_q[l];
            eff[l][SEC_BIT] = sec_sum;
            eff[l][OVF_BIT] = ovf_sum;
         end
      end else begin : g_ln
         assign eff[l] = stat_q[l];
      end
      assign link_pend[l]   = |(eff[l] & en_q[l]);
      assign link_en_any[l] = |en_q[l];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |link_pend;
   end

   // register read, one cycle of latency
   word_t rd_nxt;
   always_comb begin
      rd_nxt = '0;
      for (int l = 0; l < NUM_LINKS; l++) begin
         if (addr_i == ADDR_W'(l))                 rd_nxt = DATA_W'(eff[l]);
         if (addr_i == LINK_EN_BASE + ADDR_W'(l))  rd_nxt = DATA_W'(en_q[l]);
      end
      case (addr_i)
         OVF_STAT_A: rd_nxt = DATA_W'(ovf_q);
         OVF_EN_A:   rd_nxt = DATA_W'(ovf_en_q);
         CELL_CS_A:  begin
            rd_nxt[0 +: NUM_GROUPS] = rdy_q;
            rd_nxt[8 +: NUM_GROUPS] = frm_q;
         end
         FRM_EN_A:   rd_nxt = DATA_W'(frm_en_q);
         CELL_EN_A:  rd_nxt = DATA_W'(cell_en_q);
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data_o <= '0;
      else        rd_data_o <= rd_nxt;
   end

   // R6
   ovf_summary_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == OVF_EN_A && wr_data_i[OVF_W-1:0] == '0) |=> !ovf_sum);
   // R8
   sec_cell_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == CELL_EN_A && wr_data_i[NUM_GROUPS-1:0] == '0) |=> !sec_sum);
   // R4
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|link_en_any));
   // R1
   irq_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/tb_irq_link_aggregator.sv
module tb_irq_link_aggregator;
   localparam int NL = 4, SW = 10, NG = 8;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [NL*SW-1:0] evt = '0;
   logic [12:0] ovf_evt = '0;
   logic [NG-1:0] cell_done = '0, frame_end = '0;
   logic wr_en = 1'b0;
   logic [5:0] addr = '0;
   logic [15:0] wdata = '0, rd_data;
   logic irq;
   int errors = 0, checks = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   irq_link_aggregator #(.NUM_LINKS(NL), .SRC_W(SW), .NUM_GROUPS(NG), .ADDR_W(6)) dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .ovf_evt_i(ovf_evt),
      .cell_done_i(cell_done), .frame_end_i(frame_end), .wr_en_i(wr_en),
      .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rd_data), .irq_o(irq));

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic [5:0] a, output logic [15:0] d);
      @(negedge clk); addr = a;
      @(negedge clk); d = rd_data;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 irq", {15'b0, irq}, 16'h0);
      foreach (v[i]) ;
      for (int a = 0; a < NL; a++) begin
         rd(6'(a), v); chk("R1 status", v, 16'h0);
         rd(6'h10 + 6'(a), v); chk("R1 enable", v, 16'h0);
      end
      for (int a = 6'h20; a <= 6'h24; a++) begin
         rd(6'(a), v); chk("R1 second level", v, 16'h0);
      end
      // R10: unmapped address
      rd(6'h3f, v); chk("R10 unmapped", v, 16'h0);

      // sweep over ordinary sources
      for (int l = 0; l < NL; l++) begin
         for (int s = 0; s < SW; s++) begin
            if (l == 0 && (s == 7 || s == 8)) continue;
            @(negedge clk); evt[l*SW+s] = 1'b1;
            @(negedge clk); evt = '0;
            rd(6'(l), v); chk("R2 event sets", v, 16'(1) << s);
            chk("R4 disabled irq", {15'b0, irq}, 16'h0);
            wr(6'h10 + 6'(l), 16'(1) << s); settle();
            chk("R4 enabled irq", {15'b0, irq}, 16'h1);
            wr(6'h10 + 6'(l), 16'h0); settle();
            chk("R5 masked irq", {15'b0, irq}, 16'h0);
            rd(6'(l), v); chk("R5 status kept", v, 16'(1) << s);
            wr(6'h10 + 6'(l), 16'(1) << s); settle();
            chk("R5 reenabled irq", {15'b0, irq}, 16'h1);
            wr(6'(l), 16'hffff);
            rd(6'(l), v); chk("R2 write one holds", v, 16'(1) << s);
            wr(6'(l), 16'h0); settle();
            rd(6'(l), v); chk("R2 write zero clears", v, 16'h0);
            chk("R4 cleared irq", {15'b0, irq}, 16'h0);
            wr(6'h10 + 6'(l), 16'h0);
         end
      end

      // R3: event and clear in the same cycle
      @(negedge clk); evt[2*SW+3] = 1'b1; wr_en = 1'b1; addr = 6'd2; wdata = 16'h0;
      @(negedge clk); evt = '0; wr_en = 1'b0;
      rd(6'd2, v); chk("R3 event wins", v, 16'h0008);
      wr(6'd2, 16'h0);

      // R6/R7: overflow sources
      for (int b = 0; b < 13; b++) begin
         @(negedge clk); ovf_evt[b] = 1'b1;
         @(negedge clk); ovf_evt = '0;
         rd(6'h20, v); chk("R7 overflow latch", v, 16'(1) << b);
         rd(6'h00, v); chk("R6 bit8 gated off", v, 16'h0);
         wr(6'h21, 16'(1) << b);
         rd(6'h00, v); chk("R6 bit8 live", v, 16'h0100);
         wr(6'h00, 16'h0);
         rd(6'h00, v); chk("R6 write ignored", v, 16'h0100);
         wr(6'h21, 16'h0);
         rd(6'h00, v); chk("R6 bit8 falls", v, 16'h0);
         wr(6'h20, 16'h0);
         rd(6'h20, v); chk("R7 overflow clear", v, 16'h0);
      end
      // R4 through bit 8
      @(negedge clk); ovf_evt[12] = 1'b1;
      @(negedge clk); ovf_evt = '0;
      wr(6'h21, 16'h1000); wr(6'h10, 16'h0100); settle();
      chk("R4 irq via overflow", {15'b0, irq}, 16'h1);
      wr(6'h21, 16'h0); settle();
      chk("R6 irq drops with enable", {15'b0, irq}, 16'h0);
      wr(6'h20, 16'h0); wr(6'h10, 16'h0);

      // R8/R9: groups
      for (int g = 0; g < NG; g++) begin
         @(negedge clk); cell_done[g] = 1'b1;
         @(negedge clk); cell_done = '0;
         rd(6'h22, v); chk("R9 ready latch", v, 16'(1) << g);
         rd(6'h00, v); chk("R8 no enables", v, 16'h0);
         wr(6'h23, 16'(1) << g);
         rd(6'h00, v); chk("R8 frame enable only", v, 16'h0);
         wr(6'h24, 16'(1) << g);
         rd(6'h00, v); chk("R8 both enables", v, 16'h0080);
         wr(6'h22, 16'h0);
         rd(6'h00, v); chk("R9 ready cleared", v, 16'h0);
         @(negedge clk); frame_end[g] = 1'b1;
         @(negedge clk); frame_end = '0;
         rd(6'h22, v); chk("R9 frame latch", v, 16'(1) << (8 + g));
         rd(6'h00, v); chk("R8 frame event", v, 16'h0080);
         wr(6'h23, 16'h0);
         rd(6'h00, v); chk("R8 cell enable only", v, 16'h0);
         wr(6'h22, 16'hffff);
         rd(6'h22, v); chk("R9 write one holds", v, 16'(1) << (8 + g));
         wr(6'h22, 16'h0);
         rd(6'h22, v); chk("R9 frame cleared", v, 16'h0);
         wr(6'h24, 16'h0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule